// File: doc/BRIEF.md
# JTAG Debug Transaction Engine

This block sits behind a JTAG test access port and lets an external debugger read and write 32-bit words in three target spaces: core registers, auxiliary registers and word-addressed memory. The debugger picks a data register with a 4-bit instruction. The choices are a command register, an address register, a data register, a status register, an identification register and the one-bit bypass register. Each bus access is started by the TAP moving from Update-DR straight into Run-Test/Idle.

The command register latches an access kind, and that kind stays in force for every later access until the debugger replaces it. For a read, the debugger writes the address and enters Idle, which fetches the word; the next data scan returns it. For a write, the debugger writes the address and leaves through Select-DR-Scan, shifts in the data word, and then enters Idle to perform the write. After each launched access the address register steps by one for register spaces and by four for memory, so a run of sequential words needs only one address write.

The TCK side and the system clock side are joined by a toggle request/acknowledge handshake with two-flop synchronizers. On the system clock side the block presents a valid/acknowledge request port that carries the space, direction, address and write data.

Top module: `dbg_xact_engine`

## Requirements
- R1: After reset the instruction is IDCODE (code 0x1), so a 32-bit data scan returns the IDCODE parameter. Every instruction scan captures the value 4'b0001, which is shifted out LSB first.
- R2: Instruction 0xF and every unassigned code (anything other than 0x1, 0x8, 0x9, 0xA, 0xB) select a one-bit bypass register that captures 0. The data on TDO is therefore TDI delayed by one shift.
- R3: The 4-bit command register (instruction 0x9) uses bit 2 for read (1) or write (0) and bits 1:0 for the space: 01 memory, 10 core register, 11 auxiliary register. Codes with bit 3 set or bits 1:0 = 00 are NOP and launch no access. Request space encoding is the same 2-bit field.
- R4: With a write command latched, an update of the data register (instruction 0xB) that goes directly into Run-Test/Idle issues exactly one write request. The request carries the current address and the shifted word.
- R5: With a read command latched, an update of the address register (instruction 0xA) or of the data register that goes into Run-Test/Idle issues one read request. The next data-register scan captures the returned word.
- R6: Each launched access advances the address register by 1 for core and auxiliary spaces and by 4 for memory. The address register captures its current value on a scan.
- R7: An update that leaves through Select-DR-Scan, whether directly or by way of Pause-DR, issues no request. This holds for an address update while a read command is latched.
- R8: The status scan (instruction 0x8, 32 bits) returns bit 0 = busy, set while an access is outstanding, and bit 1 = sticky error, set when an acknowledge reports an error. Writing a NOP command clears the error bit.
- R9: A launch attempted while busy is dropped. It issues no second request and does not advance the address.
- R10: Five TCK cycles with TMS high reach Test-Logic-Reset, which restores IDCODE and a NOP command.
- R11: A request holds req_valid and all its fields stable until req_ack, and drops req_valid in the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | System-side synchronous reset, active high |
| tck | input | 1 | Test clock |
| tap_rst | input | 1 | TCK-side synchronous reset, active high |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| tdo | output | 1 | Test data out, updated on falling TCK |
| req_valid | output | 1 | Access request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_space | output | 2 | 01 memory, 10 core register, 11 auxiliary register |
| req_addr | output | DW | Word address (byte address for memory) |
| req_wdata | output | DW | Write data |
| req_ack | input | 1 | Access complete, one-cycle pulse |
| ack_rdata | input | DW | Read data, valid with req_ack |
| ack_err | input | 1 | Access failed, valid with req_ack |

## Verification
The launch rule is driven with update-to-Idle, update-to-Select and update-through-Pause endings under read, write and NOP commands. Comparing the request count across these endings shows that only the Idle path launches, and only for the command kinds that should. Single and back-to-back sequential accesses in each space tell the step of one apart from the step of four, and show that the latched command persists across accesses. A stalled acknowledge separates a dropped overlapping launch from a queued one, by checking both the request count and the unchanged address. Out-of-range accesses exercise the sticky error and its clearing by NOP.

// File: rtl/dbg_xact_pkg.sv
package dbg_xact_pkg;
  localparam int IR_W  = 4;
  localparam int CMD_W = 4;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_st_e;

  localparam logic [IR_W-1:0] IR_IDCODE = 4'h1;
  localparam logic [IR_W-1:0] IR_STATUS = 4'h8;
  localparam logic [IR_W-1:0] IR_CMD    = 4'h9;
  localparam logic [IR_W-1:0] IR_ADDR   = 4'hA;
  localparam logic [IR_W-1:0] IR_DATA   = 4'hB;

  typedef enum logic [2:0] {SEL_BYP, SEL_ID, SEL_STAT, SEL_CMD, SEL_ADDR, SEL_DATA} dr_sel_e;

  localparam logic [1:0] SP_MEM  = 2'b01;
  localparam logic [1:0] SP_CORE = 2'b10;
  localparam logic [1:0] SP_AUX  = 2'b11;

  // bit 3 must be clear and a space must be named for a command to act
  function automatic logic cmd_live(input logic [CMD_W-1:0] c);
    return !c[3] && (c[1:0] != 2'b00);
  endfunction
endpackage

// File: rtl/dbg_tap_fsm.sv
module dbg_tap_fsm
  import dbg_xact_pkg::*;
(
  input  logic    tck,
  input  logic    tap_rst,
  input  logic    tms,
  output tap_st_e state,
  output tap_st_e next_state
);
  always_comb begin
    case (state)
      TS_RESET:  next_state = tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   next_state = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: next_state = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: next_state = tms ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  next_state = tms ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: next_state = tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: next_state = tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: next_state = tms ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: next_state = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: next_state = tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: next_state = tms ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  next_state = tms ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: next_state = tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: next_state = tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: next_state = tms ? TS_UPD_IR : TS_SH_IR;
      TS_UPD_IR: next_state = tms ? TS_SEL_DR : TS_IDLE;
      default:   next_state = TS_RESET;
    endcase
  end

  always_ff @(posedge tck) begin
    if (tap_rst) state <= TS_RESET;
    else         state <= next_state;
  end

  // R10: holding TMS high keeps the controller in Test-Logic-Reset
  p_tlr_hold_r10: assert property (@(posedge tck) disable iff (tap_rst)
    (state == TS_RESET && tms) |=> state == TS_RESET);
endmodule

// File: rtl/dbg_tck_regs.sv
module dbg_tck_regs
  import dbg_xact_pkg::*;
#(
  parameter int              DW       = 32,
  parameter logic [DW-1:0]   IDCODE   = 32'h0A57_1D2B,
  parameter int              MEM_STEP = 4,
  parameter int              REG_STEP = 1
) (
  input  logic          tck,
  input  logic          tap_rst,
  input  logic          tdi,
  input  tap_st_e       state,
  input  tap_st_e       next_state,
  input  logic          ack_tgl,
  input  logic [DW-1:0] rd_hold,
  input  logic          err_hold,
  output logic          req_tgl,
  output logic          lq_write,
  output logic [1:0]    lq_space,
  output logic [DW-1:0] lq_addr,
  output logic [DW-1:0] lq_wdata,
  output logic          tdo
);
  localparam logic [DW-1:0] M_STEP = DW'(MEM_STEP);
  localparam logic [DW-1:0] R_STEP = DW'(REG_STEP);

  logic [IR_W-1:0]  ir, ir_sh;
  logic [CMD_W-1:0] cmd;
  logic [DW-1:0]    dr_sh, addr, eff_addr, step;
  logic             err_st, ack_s1, ack_s2, ack_seen;
  logic             busy, done, want, launch;
  dr_sel_e          sel;

  always_comb begin
    case (ir)
      IR_IDCODE: sel = SEL_ID;
      IR_STATUS: sel = SEL_STAT;
      IR_CMD:    sel = SEL_CMD;
      IR_ADDR:   sel = SEL_ADDR;
      IR_DATA:   sel = SEL_DATA;
      default:   sel = SEL_BYP;
    endcase
  end

  assign busy     = req_tgl ^ ack_seen;
  assign done     = ack_s2 ^ ack_seen;
  assign want     = (state == TS_UPD_DR) && (next_state == TS_IDLE) && cmd_live(cmd) &&
                    ((sel == SEL_DATA) || (sel == SEL_ADDR && cmd[2]));
  assign launch   = want && !busy;
  assign eff_addr = (sel == SEL_ADDR) ? dr_sh : addr;
  assign step     = (cmd[1:0] == SP_MEM) ? M_STEP : R_STEP;

  always_ff @(posedge tck) begin
    if (tap_rst || state == TS_RESET) begin
      ir     <= IR_IDCODE;
      ir_sh  <= '0;
      cmd    <= '0;
      addr   <= '0;
      dr_sh  <= '0;
      err_st <= 1'b0;
    end else begin
      case (state)
        TS_CAP_IR: ir_sh <= IR_W'(1);
        TS_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        TS_UPD_IR: ir    <= ir_sh;
        TS_CAP_DR: begin
          case (sel)
            SEL_ID:   dr_sh <= IDCODE;
            SEL_STAT: dr_sh <= {{(DW-2){1'b0}}, err_st, busy};
            SEL_CMD:  dr_sh <= {{(DW-CMD_W){1'b0}}, cmd};
            SEL_ADDR: dr_sh <= addr;
            SEL_DATA: dr_sh <= rd_hold;
            default:  dr_sh <= '0;
          endcase
        end
        TS_SH_DR: begin
          case (sel)
            SEL_CMD: dr_sh[CMD_W-1:0] <= {tdi, dr_sh[CMD_W-1:1]};
            SEL_BYP: dr_sh[0]         <= tdi;
            default: dr_sh            <= {tdi, dr_sh[DW-1:1]};
          endcase
        end
        TS_UPD_DR: begin
          if (sel == SEL_CMD)  cmd  <= dr_sh[CMD_W-1:0];
          if (sel == SEL_ADDR) addr <= dr_sh;
        end
        default: ;
      endcase
      if (launch) addr <= eff_addr + step;
      if (done && err_hold)
        err_st <= 1'b1;
      else if (state == TS_UPD_DR && sel == SEL_CMD && !cmd_live(dr_sh[CMD_W-1:0]))
        err_st <= 1'b0;
    end
  end

  // handshake state survives Test-Logic-Reset so an access in flight completes cleanly
  always_ff @(posedge tck) begin
    if (tap_rst) begin
      req_tgl  <= 1'b0;
      ack_s1   <= 1'b0;
      ack_s2   <= 1'b0;
      ack_seen <= 1'b0;
      lq_write <= 1'b0;
      lq_space <= 2'b00;
      lq_addr  <= '0;
      lq_wdata <= '0;
    end else begin
      ack_s1   <= ack_tgl;
      ack_s2   <= ack_s1;
      ack_seen <= ack_s2;
      if (launch) begin
        req_tgl  <= ~req_tgl;
        lq_write <= ~cmd[2];
        lq_space <= cmd[1:0];
        lq_addr  <= eff_addr;
        lq_wdata <= dr_sh;
      end
    end
  end

  always_ff @(negedge tck) begin
    if (tap_rst)                tdo <= 1'b0;
    else if (state == TS_SH_IR) tdo <= ir_sh[0];
    else if (state == TS_SH_DR) tdo <= dr_sh[0];
    else                        tdo <= 1'b0;
  end

  // R4: a launch only ever happens on the way into Run-Test/Idle
  p_launch_idle_r4: assert property (@(posedge tck) disable iff (tap_rst)
    launch |=> state == TS_IDLE);
  // R9: after a launch the engine reports busy until the acknowledge returns
  p_busy_after_launch_r9: assert property (@(posedge tck) disable iff (tap_rst)
    launch |=> busy);
  // R9: a launch attempt while busy leaves the request bundle untouched
  p_drop_when_busy_r9: assert property (@(posedge tck) disable iff (tap_rst)
    (want && busy) |=> $stable(lq_addr) && $stable(lq_wdata));
endmodule

// File: rtl/dbg_sys_port.sv
module dbg_sys_port #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_tgl,
  input  logic          lq_write,
  input  logic [1:0]    lq_space,
  input  logic [DW-1:0] lq_addr,
  input  logic [DW-1:0] lq_wdata,
  output logic          ack_tgl,
  output logic [DW-1:0] rd_hold,
  output logic          err_hold,
  output logic          req_valid,
  output logic          req_write,
  output logic [1:0]    req_space,
  output logic [DW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic          req_ack,
  input  logic [DW-1:0] ack_rdata,
  input  logic          ack_err
);
  logic rq_s1, rq_s2, rq_seen, rq_edge;

  assign rq_edge = rq_s2 ^ rq_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      rq_s1     <= 1'b0;
      rq_s2     <= 1'b0;
      rq_seen   <= 1'b0;
      ack_tgl   <= 1'b0;
      rd_hold   <= '0;
      err_hold  <= 1'b0;
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_space <= 2'b00;
      req_addr  <= '0;
      req_wdata <= '0;
    end else begin
      rq_s1   <= req_tgl;
      rq_s2   <= rq_s1;
      rq_seen <= rq_s2;
      if (rq_edge) begin
        req_valid <= 1'b1;
        req_write <= lq_write;
        req_space <= lq_space;
        req_addr  <= lq_addr;
        req_wdata <= lq_wdata;
      end else if (req_valid && req_ack) begin
        req_valid <= 1'b0;
        rd_hold   <= ack_rdata;
        err_hold  <= ack_err;
        ack_tgl   <= ~ack_tgl;
      end
    end
  end

  // R11: an unacknowledged request keeps every field steady
  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ack) |=> req_valid && $stable(req_addr) && $stable(req_wdata)
                               && $stable(req_space) && $stable(req_write));
  // R11: the acknowledge retires the request in the next cycle
  p_req_retire_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ack) |=> !req_valid);
  // R9: the TCK side never posts a new request while one is outstanding
  p_single_pending_r9: assert property (@(posedge clk) disable iff (rst)
    rq_edge |-> !req_valid);
endmodule

// File: rtl/dbg_xact_engine.sv
module dbg_xact_engine
  import dbg_xact_pkg::*;
#(
  parameter int            DW       = 32,
  parameter logic [DW-1:0] IDCODE   = 32'h0A57_1D2B,
  parameter int            MEM_STEP = 4,
  parameter int            REG_STEP = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tck,
  input  logic          tap_rst,
  input  logic          tms,
  input  logic          tdi,
  output logic          tdo,
  output logic          req_valid,
  output logic          req_write,
  output logic [1:0]    req_space,
  output logic [DW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic          req_ack,
  input  logic [DW-1:0] ack_rdata,
  input  logic          ack_err
);
  tap_st_e       state, next_state;
  logic          req_tgl, ack_tgl, lq_write, err_hold;
  logic [1:0]    lq_space;
  logic [DW-1:0] lq_addr, lq_wdata, rd_hold;

  dbg_tap_fsm u_fsm (
    .tck(tck), .tap_rst(tap_rst), .tms(tms), .state(state), .next_state(next_state)
  );

  dbg_tck_regs #(
    .DW(DW), .IDCODE(IDCODE), .MEM_STEP(MEM_STEP), .REG_STEP(REG_STEP)
  ) u_regs (
    .tck(tck), .tap_rst(tap_rst), .tdi(tdi), .state(state), .next_state(next_state),
    .ack_tgl(ack_tgl), .rd_hold(rd_hold), .err_hold(err_hold),
    .req_tgl(req_tgl), .lq_write(lq_write), .lq_space(lq_space),
    .lq_addr(lq_addr), .lq_wdata(lq_wdata), .tdo(tdo)
  );

  dbg_sys_port #(.DW(DW)) u_port (
    .clk(clk), .rst(rst), .req_tgl(req_tgl), .lq_write(lq_write), .lq_space(lq_space),
    .lq_addr(lq_addr), .lq_wdata(lq_wdata), .ack_tgl(ack_tgl), .rd_hold(rd_hold),
    .err_hold(err_hold), .req_valid(req_valid), .req_write(req_write),
    .req_space(req_space), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ack(req_ack), .ack_rdata(ack_rdata), .ack_err(ack_err)
  );
endmodule

// File: tb/dbg_xact_engine_tb_top.sv
module dbg_xact_engine_tb_top;
  localparam logic [31:0] ID_VAL = 32'h0A57_1D2B;

  logic clk = 1'b0, rst = 1'b1, tck = 1'b0, tap_rst = 1'b1, tms = 1'b1, tdi = 1'b0;
  logic tdo, req_valid, req_write, req_ack, ack_err;
  logic [1:0]  req_space;
  logic [31:0] req_addr, req_wdata, ack_rdata;

  always #5 clk = ~clk;

  dbg_xact_engine #(.DW(32), .IDCODE(ID_VAL)) dut_i (
    .clk(clk), .rst(rst), .tck(tck), .tap_rst(tap_rst), .tms(tms), .tdi(tdi), .tdo(tdo),
    .req_valid(req_valid), .req_write(req_write), .req_space(req_space),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
    .ack_rdata(ack_rdata), .ack_err(ack_err)
  );

  // ---- target model: core/aux register files and word memory ----
  logic [31:0] core_rf [16];
  logic [31:0] aux_rf  [16];
  logic [31:0] mem     [64];
  logic        stall = 1'b0;
  int          xact_cnt = 0;
  logic        last_write;
  logic [1:0]  last_space;
  logic [31:0] last_addr, last_wdata;

  function automatic logic bad_addr(input logic [1:0] sp, input logic [31:0] a);
    if (sp == 2'b01) return a[31:8] != 0;
    return a[31:4] != 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      req_ack   <= 1'b0;
      ack_err   <= 1'b0;
      ack_rdata <= '0;
    end else if (req_valid && !req_ack && !stall) begin
      req_ack    <= 1'b1;
      ack_err    <= bad_addr(req_space, req_addr);
      xact_cnt   <= xact_cnt + 1;
      last_write <= req_write;
      last_space <= req_space;
      last_addr  <= req_addr;
      last_wdata <= req_wdata;
      case (req_space)
        2'b01:   ack_rdata <= mem[req_addr[7:2]];
        2'b10:   ack_rdata <= core_rf[req_addr[3:0]];
        default: ack_rdata <= aux_rf[req_addr[3:0]];
      endcase
      if (req_write && !bad_addr(req_space, req_addr)) begin
        case (req_space)
          2'b01:   mem[req_addr[7:2]]     <= req_wdata;
          2'b10:   core_rf[req_addr[3:0]] <= req_wdata;
          default: aux_rf[req_addr[3:0]]  <= req_wdata;
        endcase
      end
    end else begin
      req_ack <= 1'b0;
    end
  end

  // ---- bookkeeping ----
  int   n_checks = 0, n_errors = 0;
  logic at_idle = 1'b0;
  logic finished = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d, output logic o);
    o = tdo;
    tms = m;
    tdi = d;
    #20 tck = 1'b1;
    #40 tck = 1'b0;
    #20;
  endtask

  task automatic settle(input int n);
    logic b;
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, b);
  endtask

  task automatic ir_scan(input logic [3:0] code, output logic [3:0] cap);
    logic b;
    if (at_idle) tick(1'b1, 1'b0, b);
    tick(1'b1, 1'b0, b);
    tick(1'b0, 1'b0, b);
    tick(1'b0, 1'b0, b);
    for (int i = 0; i < 4; i++) begin
      tick(i == 3, code[i], b);
      cap[i] = b;
    end
    tick(1'b1, 1'b0, b);
    tick(1'b0, 1'b0, b);
    at_idle = 1'b1;
  endtask

  task automatic dr_scan(input int len, input logic [31:0] din, input logic via_pause,
                         input logic to_idle, output logic [31:0] dout);
    logic b;
    dout = '0;
    if (at_idle) tick(1'b1, 1'b0, b);
    tick(1'b0, 1'b0, b);
    tick(1'b0, 1'b0, b);
    for (int i = 0; i < len; i++) begin
      tick(i == len - 1, din[i], b);
      dout[i] = b;
    end
    if (via_pause) begin
      tick(1'b0, 1'b0, b);
      tick(1'b1, 1'b0, b);
      tick(1'b1, 1'b0, b);
    end else begin
      tick(1'b1, 1'b0, b);
    end
    tick(!to_idle, 1'b0, b);
    at_idle = to_idle;
  endtask

  task automatic set_cmd(input logic [3:0] c);
    logic [3:0]  cap;
    logic [31:0] v;
    ir_scan(4'h9, cap);
    dr_scan(4, {28'h0, c}, 1'b0, 1'b0, v);
  endtask

  task automatic write_addr(input logic [31:0] a, input logic to_idle);
    logic [3:0]  cap;
    logic [31:0] v;
    ir_scan(4'hA, cap);
    dr_scan(32, a, 1'b0, to_idle, v);
  endtask

  // reads the address by shifting its expected value back in
  task automatic check_addr(input string tag, input logic [31:0] exp);
    logic [3:0]  cap;
    logic [31:0] v;
    ir_scan(4'hA, cap);
    dr_scan(32, exp, 1'b0, 1'b0, v);
    check(tag, v, exp);
  endtask

  task automatic read_status(input string tag, input logic [31:0] exp);
    logic [3:0]  cap;
    logic [31:0] v;
    ir_scan(4'h8, cap);
    dr_scan(32, 32'h0, 1'b0, 1'b1, v);
    check(tag, v, exp);
  endtask

  // ---- scenarios ----
  task automatic t_reset_state();
    logic [3:0]  cap;
    logic [31:0] v;
    dr_scan(32, 32'h0, 1'b0, 1'b1, v);
    check("R1 idcode after reset", v, ID_VAL);
    ir_scan(4'h1, cap);
    check("R1 ir capture", {28'h0, cap}, 32'h1);
    check("R11 no request after reset", {31'h0, req_valid}, 32'h0);
  endtask

  task automatic t_bypass();
    logic [3:0]  cap;
    logic [31:0] v;
    ir_scan(4'hF, cap);
    dr_scan(8, 32'hB6, 1'b0, 1'b1, v);
    check("R2 bypass 0xF", v, 32'h6C);
    ir_scan(4'h3, cap);
    dr_scan(8, 32'h5A, 1'b0, 1'b1, v);
    check("R2 bypass unknown code", v, 32'hB4);
  endtask

  task automatic t_core_write();
    logic [3:0]  cap;
    logic [31:0] v;
    int          c0 = xact_cnt;
    set_cmd(4'h2);
    write_addr(32'd3, 1'b0);
    check("R4 address update toward Select issues nothing", xact_cnt - c0, 0);
    ir_scan(4'hB, cap);
    dr_scan(32, 32'hA5A5_0003, 1'b0, 1'b1, v);
    settle(12);
    check("R4 one write request", xact_cnt - c0, 1);
    check("R4 write dir", {31'h0, last_write}, 32'h1);
    check("R3 core space 10", {30'h0, last_space}, 32'h2);
    check("R4 write addr", last_addr, 32'd3);
    check("R4 stored word", core_rf[3], 32'hA5A5_0003);
    check_addr("R6 core step 1", 32'd4);
  endtask

  task automatic t_core_read();
    logic [3:0]  cap;
    logic [31:0] v;
    int          c0 = xact_cnt;
    set_cmd(4'h6);
    write_addr(32'd5, 1'b1);
    settle(12);
    check("R5 address into Idle fetches", xact_cnt - c0, 1);
    check("R5 read dir", {31'h0, last_write}, 32'h0);
    ir_scan(4'hB, cap);
    dr_scan(32, 32'h0, 1'b0, 1'b1, v);
    check("R5 first word", v, 32'hC0DE_0005);
    settle(12);
    dr_scan(32, 32'h0, 1'b0, 1'b0, v);
    check("R5 sequential word", v, 32'hC0DE_0006);
    check("R5 two fetches", xact_cnt - c0, 2);
    check_addr("R6 step 1 after two reads", 32'd7);
  endtask

  task automatic t_mem();
    logic [3:0]  cap;
    logic [31:0] v;
    int          c0;
    set_cmd(4'h5);
    write_addr(32'h10, 1'b1);
    settle(12);
    ir_scan(4'hB, cap);
    dr_scan(32, 32'h0, 1'b0, 1'b1, v);
    check("R6 mem word 0x10", v, 32'h4D00_0404);
    settle(12);
    dr_scan(32, 32'h0, 1'b0, 1'b1, v);
    check("R6 mem word 0x14", v, 32'h4D00_0505);
    settle(12);
    dr_scan(32, 32'h0, 1'b0, 1'b0, v);
    check("R6 mem word 0x18", v, 32'h4D00_0606);
    check("R3 mem space 01", {30'h0, last_space}, 32'h1);
    check_addr("R6 mem step 4", 32'h1C);
    c0 = xact_cnt;
    set_cmd(4'h1);
    write_addr(32'h20, 1'b0);
    ir_scan(4'hB, cap);
    dr_scan(32, 32'h1111_2222, 1'b0, 1'b1, v);
    settle(12);
    dr_scan(32, 32'h3333_4444, 1'b0, 1'b1, v);
    settle(12);
    check("R3 latched write persists", xact_cnt - c0, 2);
    check("R4 mem word 8", mem[8], 32'h1111_2222);
    check("R6 mem word 9", mem[9], 32'h3333_4444);
    check_addr("R6 mem step 4 writes", 32'h28);
  endtask

  task automatic t_aux();
    logic [3:0]  cap;
    logic [31:0] v;
    set_cmd(4'h3);
    write_addr(32'd2, 1'b0);
    ir_scan(4'hB, cap);
    dr_scan(32, 32'hAAAA_0002, 1'b0, 1'b1, v);
    settle(12);
    check("R3 aux write stored", aux_rf[2], 32'hAAAA_0002);
    check("R3 aux space 11", {30'h0, last_space}, 32'h3);
    set_cmd(4'h7);
    write_addr(32'd2, 1'b1);
    settle(12);
    ir_scan(4'hB, cap);
    dr_scan(32, 32'h0, 1'b0, 1'b0, v);
    check("R3 aux read", v, 32'hAAAA_0002);
  endtask

  task automatic t_nop();
    logic [3:0]  cap;
    logic [31:0] v;
    int          c0 = xact_cnt;
    set_cmd(4'h0);
    ir_scan(4'hB, cap);
    dr_scan(32, 32'h1234_5678, 1'b0, 1'b1, v);
    settle(12);
    check("R3 NOP launches nothing", xact_cnt - c0, 0);
    set_cmd(4'h4);
    write_addr(32'd1, 1'b1);
    settle(12);
    set_cmd(4'hE);
    write_addr(32'd1, 1'b1);
    settle(12);
    check("R3 codes 0x4 and 0xE act as NOP", xact_cnt - c0, 0);
    check("R3 core reg 1 untouched", core_rf[1], 32'hC0DE_0001);
  endtask

  task automatic t_no_idle();
    logic [3:0]  cap;
    logic [31:0] v;
    int          c0 = xact_cnt;
    set_cmd(4'h6);
    ir_scan(4'hA, cap);
    dr_scan(32, 32'd9, 1'b1, 1'b0, v);
    settle(0);
    dr_scan(32, 32'd9, 1'b0, 1'b0, v);
    ir_scan(4'h8, cap);
    settle(12);
    check("R7 Select or Pause exit issues nothing", xact_cnt - c0, 0);
    ir_scan(4'hA, cap);
    dr_scan(32, 32'd9, 1'b1, 1'b1, v);
    settle(12);
    check("R7 Pause then Idle issues one read", xact_cnt - c0, 1);
    check("R7 read addr", last_addr, 32'd9);
  endtask

  task automatic t_busy();
    logic [3:0]  cap;
    logic [31:0] v;
    int          c0 = xact_cnt;
    set_cmd(4'h2);
    write_addr(32'd8, 1'b0);
    stall = 1'b1;
    ir_scan(4'hB, cap);
    dr_scan(32, 32'hBEEF_0008, 1'b0, 1'b1, v);
    settle(4);
    check("R11 request held", {31'h0, req_valid}, 32'h1);
    check("R11 addr held", req_addr, 32'd8);
    read_status("R8 busy bit", 32'h1);
    ir_scan(4'hB, cap);
    dr_scan(32, 32'hDEAD_0009, 1'b0, 1'b1, v);
    settle(4);
    check("R11 addr still held", req_addr, 32'd8);
    stall = 1'b0;
    settle(12);
    check("R9 overlapping launch dropped", xact_cnt - c0, 1);
    check("R9 first word stored", core_rf[8], 32'hBEEF_0008);
    check("R9 core reg 9 untouched", core_rf[9], 32'hC0DE_0009);
    read_status("R8 idle status", 32'h0);
    check_addr("R9 address stepped once", 32'd9);
  endtask

  task automatic t_error();
    logic [3:0]  cap;
    logic [31:0] v;
    set_cmd(4'h2);
    write_addr(32'd20, 1'b0);
    ir_scan(4'hB, cap);
    dr_scan(32, 32'h0000_0BAD, 1'b0, 1'b1, v);
    settle(12);
    read_status("R8 sticky error set", 32'h2);
    write_addr(32'd1, 1'b0);
    ir_scan(4'hB, cap);
    dr_scan(32, 32'h0000_0001, 1'b0, 1'b1, v);
    settle(12);
    read_status("R8 error stays after good access", 32'h2);
    set_cmd(4'h0);
    read_status("R8 NOP clears error", 32'h0);
  endtask

  task automatic t_tap_reset();
    logic [3:0]  cap;
    logic [31:0] v;
    logic        b;
    set_cmd(4'h3);
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, b);
    tick(1'b0, 1'b0, b);
    at_idle = 1'b1;
    dr_scan(32, 32'h0, 1'b0, 1'b1, v);
    check("R10 idcode after TMS reset", v, ID_VAL);
    ir_scan(4'h9, cap);
    dr_scan(4, 32'h0, 1'b0, 1'b1, v);
    check("R10 command back to NOP", v, 32'h0);
  endtask

  initial begin
    logic b;
    for (int i = 0; i < 16; i++) begin
      core_rf[i] = 32'hC0DE_0000 + i;
      aux_rf[i]  = 32'hA0C5_0000 + i;
    end
    for (int i = 0; i < 64; i++) mem[i] = 32'h4D00_0000 | (i << 8) | i;
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, b);
    tap_rst = 1'b0;
    rst     = 1'b0;
    tick(1'b0, 1'b0, b);
    at_idle = 1'b1;
    t_reset_state();
    t_bypass();
    t_core_write();
    t_core_read();
    t_mem();
    t_aux();
    t_nop();
    t_no_idle();
    t_busy();
    t_error();
    t_tap_reset();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule